// File: doc/BRIEF.md
# Glitch-Safe Divider Update Sequencer

This block turns a single request for a new synthesizer divider setting into an ordered series of register writes. A downstream serial-port master consumes them. The synthesizer's integer divider is not double buffered. If every upper bit of that divider drops out at the same moment during a change, the divider can mis-load. The sequencer avoids this by first writing an intermediate value, which is the bitwise OR of the present and the target integer divider. The OR keeps at least one high upper bit alive across each step.

A request gives the operating mode, the present integer divider value, the target integer divider value and the target fractional value. The block then checks whether the change is hazardous, meaning that no upper bit is high in both the present and the target value. In fractional mode, the integer update is placed between two groups of writes. Before it, the seed register and the fractional register are cleared. After it, the seed is restored to a non-zero constant and the fractional register gets its final value. In integer mode, only the integer register is written. Each write is offered on a valid/ready pair, and a one-cycle done pulse follows the last accepted write.

Top module: `divupd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `wr_valid_o`, `done_o` and `hazard_o` are all low.
- R2: In fractional mode with a hazard, the block issues these writes as (address, data): (5, 0), (4, 0), (3, intermediate), (3, target integer), (5, 0x50894C), (4, target fractional).
- R3: In integer mode with a hazard, the block issues exactly two writes: (3, intermediate), then (3, target integer).
- R4: The intermediate data is the present value ORed with the target value, zero-extended to 24 bits. For example, 0x0074 and 0x0080 give 0x0000F4.
- R5: The hazard is present when no bit in positions 15 down to 5 is set in both the present and the target value. `hazard_o` reports the hazard for the accepted request from the cycle after acceptance until the next request is accepted.
- R6: Without a hazard, the intermediate write is left out. Integer mode issues only (3, target). Fractional mode keeps the clearing writes before the integer write and the restoring writes after it.
- R7: The first write appears on the outputs in the cycle after a start is accepted. Each write holds its address and data steady until `wr_ready_i` is sampled high.
- R8: A start request is ignored while `wr_valid_o` is high.
- R9: After a write is accepted, the next write appears in the following cycle. After the last write is accepted, `done_o` is high for exactly that following cycle, with `wr_valid_o` low.
- R10: The mode and all three values are sampled only in the cycle the start is accepted. Later changes to them have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a divider update |
| frac_mode_i | input | 1 | 1 = fractional mode, 0 = integer mode |
| cur_int_i | input | 16 | Integer divider value now loaded |
| tgt_int_i | input | 16 | Target integer divider value |
| tgt_frac_i | input | 24 | Target fractional divider value |
| wr_addr_o | output | 4 | Register address of the offered write |
| wr_data_o | output | 24 | Data of the offered write |
| wr_valid_o | output | 1 | A write is offered |
| wr_ready_i | input | 1 | Downstream accepts the offered write |
| done_o | output | 1 | One-cycle pulse after the final write is accepted |
| hazard_o | output | 1 | Hazard flag of the accepted request |

## Verification
The bench builds the block with its default parameters: a 16-bit divider with an 11-bit upper guard field, 24-bit data, and registers at 3, 4 and 5. With these values, the 0x74 to 0x80 case and a value whose upper bits are all zero can both be reached exactly. A guard field this wide also makes random values share an upper bit most of the time, so the stimulus forces disjoint pairs on purpose to reach the hazard branch as well. The ready input runs at constant high first, for back-to-back traffic, and then follows a pseudo-random pattern that produces long holds. Meanwhile, start and the request fields change every cycle, so that requests arriving during a sequence and late changes to the request values are both exercised.

// File: rtl/divseq_pkg.sv
package divseq_pkg;

  typedef enum logic [2:0] {
    STP_IDLE,
    STP_SEED_CLR,
    STP_FRAC_CLR,
    STP_MID,
    STP_FINAL,
    STP_SEED_SET,
    STP_FRAC_SET
  } step_e;

  // first write of a freshly accepted request
  function automatic step_e first_step(input logic frac, input logic haz);
    if (frac)     return STP_SEED_CLR;
    else if (haz) return STP_MID;
    else          return STP_FINAL;
  endfunction

  // successor of a write once it has been accepted
  function automatic step_e next_step(input step_e s, input logic frac, input logic haz);
    case (s)
      STP_SEED_CLR: return STP_FRAC_CLR;
      STP_FRAC_CLR: return haz ? STP_MID : STP_FINAL;
      STP_MID:      return STP_FINAL;
      STP_FINAL:    return frac ? STP_SEED_SET : STP_IDLE;
      STP_SEED_SET: return STP_FRAC_SET;
      default:      return STP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/divseq_plan.sv
// Computes the bridging value and the hazard flag from two divider values.
module divseq_plan #(
  parameter int DIV_W   = 16,
  parameter int GUARD_W = 11
) (
  input  logic [DIV_W-1:0] from_i,
  input  logic [DIV_W-1:0] to_i,
  output logic [DIV_W-1:0] mid_o,
  output logic             hazard_o
);
  localparam int LOW_W = DIV_W - GUARD_W;

  logic [GUARD_W-1:0] keep;

  for (genvar g = 0; g < GUARD_W; g++) begin : g_keep
    assign keep[g] = from_i[LOW_W+g] & to_i[LOW_W+g];
  end

  assign hazard_o = ~|keep;
  assign mid_o    = from_i | to_i;

endmodule

// File: rtl/divseq_ctrl.sv
// Step sequencing and request capture.
module divseq_ctrl
  import divseq_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              frac_mode_i,
  input  logic [DIV_W-1:0]  tgt_int_i,
  input  logic [DATA_W-1:0] tgt_frac_i,
  input  logic [DIV_W-1:0]  mid_i,
  input  logic              haz_i,
  input  logic              wr_ready_i,
  output step_e             step_d_o,
  output logic              load_o,
  output logic [DIV_W-1:0]  mid_s_o,
  output logic [DIV_W-1:0]  fin_s_o,
  output logic [DATA_W-1:0] frc_s_o,
  output logic              done_o,
  output logic              hazard_o
);
  step_e             step_q;
  logic              frac_q;
  logic              haz_q;
  logic [DIV_W-1:0]  mid_q;
  logic [DIV_W-1:0]  fin_q;
  logic [DATA_W-1:0] frc_q;
  logic              done_q;

  logic  go;
  logic  fire;
  step_e nxt;

  assign go   = (step_q == STP_IDLE) && start_i;
  assign fire = (step_q != STP_IDLE) && wr_ready_i;
  assign nxt  = next_step(step_q, frac_q, haz_q);

  always_comb begin
    if (go)        step_d_o = first_step(frac_mode_i, haz_i);
    else if (fire) step_d_o = nxt;
    else           step_d_o = step_q;
  end

  assign load_o  = go | fire;
  assign mid_s_o = go ? mid_i      : mid_q;
  assign fin_s_o = go ? tgt_int_i  : fin_q;
  assign frc_s_o = go ? tgt_frac_i : frc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STP_IDLE;
      frac_q <= 1'b0;
      haz_q  <= 1'b0;
      mid_q  <= '0;
      fin_q  <= '0;
      frc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d_o;
      done_q <= fire && (nxt == STP_IDLE);
      if (go) begin
        frac_q <= frac_mode_i;
        haz_q  <= haz_i;
        mid_q  <= mid_i;
        fin_q  <= tgt_int_i;
        frc_q  <= tgt_frac_i;
      end
    end
  end

  assign done_o   = done_q;
  assign hazard_o = haz_q;

endmodule

// File: rtl/divseq_wrport.sv
// Registered write-request outputs, loaded whenever the step advances.
module divseq_wrport
  import divseq_pkg::*;
#(
  parameter int              DIV_W    = 16,
  parameter int              DATA_W   = 24,
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] A_INT  = 3,
  parameter logic [ADDR_W-1:0] A_FRAC = 4,
  parameter logic [ADDR_W-1:0] A_SEED = 5,
  parameter logic [DATA_W-1:0] SEED_VAL = 24'h50894C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  step_e             step_i,
  input  logic [DIV_W-1:0]  mid_i,
  input  logic [DIV_W-1:0]  fin_i,
  input  logic [DATA_W-1:0] frc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    addr_d = A_INT;
    data_d = '0;
    case (step_i)
      STP_SEED_CLR: begin addr_d = A_SEED; data_d = '0;            end
      STP_FRAC_CLR: begin addr_d = A_FRAC; data_d = '0;            end
      STP_MID:      begin addr_d = A_INT;  data_d = DATA_W'(mid_i); end
      STP_FINAL:    begin addr_d = A_INT;  data_d = DATA_W'(fin_i); end
      STP_SEED_SET: begin addr_d = A_SEED; data_d = SEED_VAL;      end
      STP_FRAC_SET: begin addr_d = A_FRAC; data_d = frc_i;         end
      default:      begin addr_d = A_INT;  data_d = '0;            end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      addr_o  <= addr_d;
      data_o  <= data_d;
      valid_o <= (step_i != STP_IDLE);
    end
  end

endmodule

// File: rtl/divupd_seq.sv
module divupd_seq
  import divseq_pkg::*;
#(
  parameter int              DIV_W    = 16,
  parameter int              GUARD_W  = 11,
  parameter int              DATA_W   = 24,
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] A_INT  = 3,
  parameter logic [ADDR_W-1:0] A_FRAC = 4,
  parameter logic [ADDR_W-1:0] A_SEED = 5,
  parameter logic [DATA_W-1:0] SEED_VAL = 24'h50894C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              frac_mode_i,
  input  logic [DIV_W-1:0]  cur_int_i,
  input  logic [DIV_W-1:0]  tgt_int_i,
  input  logic [DATA_W-1:0] tgt_frac_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              done_o,
  output logic              hazard_o
);
  logic [DIV_W-1:0]  mid_w;
  logic              haz_w;
  step_e             step_d;
  logic              load;
  logic [DIV_W-1:0]  mid_s;
  logic [DIV_W-1:0]  fin_s;
  logic [DATA_W-1:0] frc_s;

  divseq_plan #(.DIV_W(DIV_W), .GUARD_W(GUARD_W)) u_plan (
    .from_i   (cur_int_i),
    .to_i     (tgt_int_i),
    .mid_o    (mid_w),
    .hazard_o (haz_w)
  );

  divseq_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .frac_mode_i (frac_mode_i),
    .tgt_int_i   (tgt_int_i),
    .tgt_frac_i  (tgt_frac_i),
    .mid_i       (mid_w),
    .haz_i       (haz_w),
    .wr_ready_i  (wr_ready_i),
    .step_d_o    (step_d),
    .load_o      (load),
    .mid_s_o     (mid_s),
    .fin_s_o     (fin_s),
    .frc_s_o     (frc_s),
    .done_o      (done_o),
    .hazard_o    (hazard_o)
  );

  divseq_wrport #(
    .DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .A_INT(A_INT), .A_FRAC(A_FRAC), .A_SEED(A_SEED), .SEED_VAL(SEED_VAL)
  ) u_wr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .step_i  (step_d),
    .mid_i   (mid_s),
    .fin_i   (fin_s),
    .frc_i   (frc_s),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o),
    .valid_o (wr_valid_o)
  );

endmodule

// File: rtl/divseq_chk.sv
module divseq_chk #(
  parameter int              DATA_W   = 24,
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] A_INT  = 3,
  parameter logic [ADDR_W-1:0] A_FRAC = 4,
  parameter logic [ADDR_W-1:0] A_SEED = 5,
  parameter logic [DATA_W-1:0] SEED_VAL = 24'h50894C
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic              done_o,
  input logic              hazard_o
);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_follows_accept_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(wr_valid_o && wr_ready_i) && !wr_valid_o));

  p_addr_legal_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (wr_addr_o == A_INT || wr_addr_o == A_FRAC || wr_addr_o == A_SEED));

  p_seed_value_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && wr_addr_o == A_SEED) |-> (wr_data_o == '0 || wr_data_o == SEED_VAL));

  p_hazard_steady_r5: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |=> $stable(hazard_o));

endmodule

bind divupd_seq divseq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .A_INT(A_INT), .A_FRAC(A_FRAC),
  .A_SEED(A_SEED), .SEED_VAL(SEED_VAL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .done_o     (done_o),
  .hazard_o   (hazard_o)
);

// File: tb/test_divupd_seq.sv
`timescale 1ns/1ps
module test_divupd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        frac_mode_i = 1'b0;
  logic [15:0] cur_int_i = '0;
  logic [15:0] tgt_int_i = '0;
  logic [23:0] tgt_frac_i = '0;
  logic [3:0]  wr_addr_o;
  logic [23:0] wr_data_o;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b0;
  logic        done_o;
  logic        hazard_o;

  always #2.5 clk = ~clk;

  divupd_seq i_divupd_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .frac_mode_i(frac_mode_i),
    .cur_int_i(cur_int_i), .tgt_int_i(tgt_int_i), .tgt_frac_i(tgt_frac_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_valid_o(wr_valid_o),
    .wr_ready_i(wr_ready_i), .done_o(done_o), .hazard_o(hazard_o)
  );

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  typedef struct { logic [3:0] a; logic [23:0] d; string tag; } wr_t;
  wr_t q[$];
  bit  m_busy = 0, m_done = 0, m_haz = 0;

  logic [15:0] lf = 16'hACE1;
  function automatic void lstep();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void push(input logic [3:0] a, input logic [23:0] d, input string tag);
    wr_t e;
    e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endfunction

  // directed requests: present, target, mode
  logic [15:0] dcur [6] = '{16'h0074, 16'h0080, 16'h0123, 16'h0123, 16'h001F, 16'hFFFF};
  logic [15:0] dtgt [6] = '{16'h0080, 16'h0074, 16'h0145, 16'h0145, 16'h0000, 16'h8000};
  bit          dfrc [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  int          didx = 0;

  initial begin
    bit haz;
    logic [15:0] mid;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "valid", 32'(wr_valid_o), 32'd0);
    chk("R1", "done", 32'(done_o), 32'd0);
    chk("R1", "hazard", 32'(hazard_o), 32'd0);
    rst = 1'b0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      // compare against model on every cycle
      chk("R7", "valid", 32'(wr_valid_o), 32'(m_busy));
      if (m_busy) begin
        chk(q[0].tag, "addr", 32'(wr_addr_o), 32'(q[0].a));
        chk(q[0].tag, "data", 32'(wr_data_o), 32'(q[0].d));
      end
      chk("R9", "done", 32'(done_o), 32'(m_done));
      chk("R5", "hazard", 32'(hazard_o), 32'(m_haz));

      // new inputs; they change every cycle, also during a sequence (R10)
      lstep();
      wr_ready_i = (cyc < 700) ? 1'b1 : (lf[0] | lf[5]) & ~(lf[9] & lf[11]);
      cur_int_i  = lf;
      lstep();
      tgt_int_i  = lf[3] ? (~cur_int_i & lf) : lf;
      lstep();
      tgt_frac_i = {lf[7:0], lf};
      frac_mode_i = lf[1];
      lstep();
      // starts are also raised while busy; the model ignores them (R8)
      start_i = (lf[2:0] == 3'd0) || (cyc % 29 == 3);
      if (start_i && !m_busy && didx < 6) begin
        cur_int_i   = dcur[didx];
        tgt_int_i   = dtgt[didx];
        frac_mode_i = dfrc[didx];
        didx++;
      end

      // reference model step
      if (!m_busy && start_i) begin
        haz = ((cur_int_i & tgt_int_i & 16'hFFE0) == 16'h0000);
        mid = cur_int_i | tgt_int_i;
        if (frac_mode_i) begin
          push(4'd5, 24'h0, haz ? "R2" : "R6");
          push(4'd4, 24'h0, haz ? "R2" : "R6");
        end
        if (haz) push(4'd3, {8'h0, mid}, "R4");
        push(4'd3, {8'h0, tgt_int_i}, haz ? (frac_mode_i ? "R2" : "R3") : "R6");
        if (frac_mode_i) begin
          push(4'd5, 24'h50894C, haz ? "R2" : "R6");
          push(4'd4, tgt_frac_i, haz ? "R2" : "R6");
        end
        m_busy = 1; m_haz = haz; m_done = 0;
      end else if (m_busy && wr_ready_i) begin
        void'(q.pop_front());
        m_done = (q.size() == 0);
        if (m_done) m_busy = 0;
      end else begin
        m_done = 0;
      end

      @(posedge clk);
      @(negedge clk);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule